// File: doc/BRIEF.md
# Deferred Invalidation Queue with Load Barrier

This block sits between a core's coherence interconnect port and its local tag array. Invalidation messages arrive carrying a line address on a valid/ready intake stream. Each accepted message is acknowledged back to the sender straight away. The block does not wait for the line to be removed from the local cache before it sends that acknowledge. Accepted messages wait in a small first-in first-out store. They drain, oldest first, through a second valid/ready stream toward the tag array, whenever that array is willing to take them.

Local loads are never compared against the waiting entries, so a load can hit a line whose invalidation is still queued and read stale data. Software that needs ordering raises a one-cycle load-barrier pulse. The block then holds a load-stall signal toward the core pipeline until every entry that was queued at the moment of the barrier has been applied. Entries that arrive after the barrier do not lengthen the stall.

Back-pressure rules: a message is accepted only in a cycle where `inv_valid` and `inv_ready` are both high. `inv_ready` is low whenever the store is full, even if an entry leaves in that same cycle. The sender must hold its message while it is not accepted. On the apply side, an entry leaves only in a cycle where `app_valid` and `app_ready` are both high. While `app_ready` is low, the offered entry and its address stay unchanged.

Top module: `invq_top`

## Requirements
- R1: `inv_ack` is high in the cycle right after each accepted message, and low in every other cycle.
- R2: `app_valid` is high exactly when the store holds at least one entry. Entries are offered whether or not a barrier has been raised.
- R3: The block has no load-address input. `ld_stall` stays low in every cycle that is not preceded by a barrier pulse or an unfinished drain, however many entries are pending.
- R4: Entries leave in arrival order, at most one per cycle. While `app_valid` is high and `app_ready` is low, `app_addr` holds its value.
- R5: The store holds 4 entries. `inv_ready` is low exactly when 4 entries are held. A message offered while `inv_ready` is low is neither stored nor acknowledged.
- R6: After a `ld_barrier` pulse, `ld_stall` is high in the next cycle exactly when entries are then held. This count includes a message accepted in the same cycle as the pulse.
- R7: `ld_stall` stays high until the last entry held at the barrier has been applied. It is low in the cycle right after that entry's apply handshake, even if younger entries remain.
- R8: A barrier raised during a running drain widens the drain to every entry held after that cycle.
- R9: After reset the store is empty, `inv_ready` is high, and `inv_ack`, `app_valid` and `ld_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Invalidation message offered |
| inv_ready | output | 1 | Store can accept a message |
| inv_addr | input | 34 | Line address of the offered message |
| inv_ack | output | 1 | Acknowledge to the sender, one cycle after acceptance |
| app_valid | output | 1 | Oldest entry offered to the tag array |
| app_ready | input | 1 | Tag array takes the offered entry |
| app_addr | output | 34 | Line address of the offered entry |
| ld_barrier | input | 1 | One-cycle load-barrier request |
| ld_stall | output | 1 | Younger loads must wait |

## Verification
`inv_ready`, `app_valid` and `app_addr` follow the registered store state, so they are due in the same cycle as the inputs that see them. `inv_ack` and any change to `ld_stall` are due one cycle after the handshake or barrier that causes them. The bench drives inputs just after a rising edge and compares every output at the following falling edge. It compares them against a model state that it commits only after the next rising edge, so every one-cycle delay is counted once. Directed runs fill the store, stall the apply side and land barriers on full, empty and same-cycle-arrival states. A long pseudo-random sweep then covers the remaining input combinations.

// File: rtl/invq_pkg.sv
package invq_pkg;
  localparam int unsigned INVQ_ADDR_W = 34;
  localparam int unsigned INVQ_DEPTH  = 4;
endpackage

// File: rtl/invq_store.sv
module invq_store #(
  parameter int unsigned ADDR_W = 34,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next
);
  logic [ADDR_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign count_next = count + CNT_W'(push) - CNT_W'(pop);
  assign head_addr  = slot[rd_ptr];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PTR_W'(gi)) slot[gi] <= push_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count_next;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && !pop) |=> (count == CNT_W'(DEPTH)));

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> (count <= CNT_W'(1)));
endmodule

// File: rtl/invq_drain.sv
module invq_drain #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             barrier,
  input  logic             pop,
  input  logic [CNT_W-1:0] held_next,
  output logic             stall
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
    end else if (barrier) begin
      left <= held_next;
    end else if (pop && left != '0) begin
      left <= left - CNT_W'(1);
    end
  end

  assign stall = (left != '0);

  p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!barrier && !pop) |=> $stable(left));

  p_drain_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!barrier && pop && left != '0) |=> (left == $past(left) - CNT_W'(1)));
endmodule

// File: rtl/invq_ack.sv
module invq_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic taken,
  output logic ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= taken;
  end
endmodule

// File: rtl/invq_top.sv
module invq_top
  import invq_pkg::*;
#(
  parameter int unsigned ADDR_W = INVQ_ADDR_W,
  parameter int unsigned DEPTH  = INVQ_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_valid,
  output logic              inv_ready,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              inv_ack,
  output logic              app_valid,
  input  logic              app_ready,
  output logic [ADDR_W-1:0] app_addr,
  input  logic              ld_barrier,
  output logic              ld_stall
);
  logic [CNT_W-1:0] held, held_next;
  logic             push, pop;

  assign inv_ready = (held != CNT_W'(DEPTH));
  assign app_valid = (held != '0);
  assign push      = inv_valid & inv_ready;
  assign pop       = app_valid & app_ready;

  invq_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(inv_addr),
    .pop(pop), .head_addr(app_addr), .count(held), .count_next(held_next)
  );

  invq_drain #(.CNT_W(CNT_W)) i_drain (
    .clk(clk), .rst_n(rst_n), .barrier(ld_barrier), .pop(pop),
    .held_next(held_next), .stall(ld_stall)
  );

  invq_ack i_ack (.clk(clk), .rst_n(rst_n), .taken(push), .ack(inv_ack));

  p_ack_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_ready) |=> inv_ack);

  p_no_ack_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_valid && inv_ready) |=> !inv_ack);

  p_apply_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (app_valid && !app_ready) |=> (app_valid && $stable(app_addr)));

  p_stall_needs_entries_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> app_valid);

  p_no_stall_without_barrier_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stall && !ld_barrier) |=> !ld_stall);

  p_barrier_sees_arrival_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_barrier && inv_valid && inv_ready) |=> ld_stall);
endmodule

// File: tb/test_invq_top.sv
`timescale 1ns/1ps
module test_invq_top;
  localparam int AW = 34;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inv_valid = 1'b0, app_ready = 1'b0, ld_barrier = 1'b0;
  logic [AW-1:0] inv_addr = '0;
  logic          inv_ready, inv_ack, app_valid, ld_stall;
  logic [AW-1:0] app_addr;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [AW-1:0] mq [DP];
  int  mc = 0, md = 0;
  bit  mack = 0;
  int  seq = 1;

  always #2.5 clk = ~clk;

  invq_top i_invq_top (
    .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_ready(inv_ready),
    .inv_addr(inv_addr), .inv_ack(inv_ack), .app_valid(app_valid),
    .app_ready(app_ready), .app_addr(app_addr), .ld_barrier(ld_barrier),
    .ld_stall(ld_stall)
  );

  task automatic chk(input string req, input string what, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // drive one cycle, compare outputs mid-cycle, then advance the model
  task automatic cyc(input bit v, input bit ar, input bit bar);
    bit push, pop, rdy;
    int nc;
    inv_valid = v; app_ready = ar; ld_barrier = bar;
    inv_addr = AW'(seq) * AW'(37) + AW'(5);
    @(negedge clk);
    rdy = (mc < DP);
    chk("R5", "inv_ready", AW'(inv_ready), AW'(rdy));
    chk("R1", "inv_ack", AW'(inv_ack), AW'(mack));
    chk("R2", "app_valid", AW'(app_valid), AW'(mc > 0));
    if (mc > 0) chk("R4", "app_addr", app_addr, mq[0]);
    chk(md > 0 ? "R7" : "R3", "ld_stall", AW'(ld_stall), AW'(md > 0));
    push = v && rdy;
    pop  = (mc > 0) && ar;
    if (pop) begin
      for (int k = 0; k < DP - 1; k++) mq[k] = mq[k+1];
      mc--;
    end
    if (push) begin
      mq[mc] = inv_addr;
      mc++;
      seq++;
    end
    nc = mc;
    if (bar) md = nc;
    else if (pop && md > 0) md--;
    mack = push;
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9", "inv_ready", AW'(inv_ready), AW'(1));
    chk("R9", "app_valid", AW'(app_valid), AW'(0));
    chk("R9", "ld_stall", AW'(ld_stall), AW'(0));
    chk("R9", "inv_ack", AW'(inv_ack), AW'(0));
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R5/R1/R3: fill with apply blocked, two extra offers refused
    for (int i = 0; i < 6; i++) cyc(1, 0, 0);
    cyc(0, 0, 0);
    // R4: drain with ready toggling, order kept
    for (int i = 0; i < 8; i++) cyc(0, i[0], 0);
    // R6: barrier on empty queue
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    // R6: barrier with same-cycle arrival
    cyc(1, 0, 1);
    cyc(0, 0, 0);
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    // R7: barrier on 3 held, younger arrivals do not extend
    for (int i = 0; i < 3; i++) cyc(1, 0, 0);
    cyc(0, 0, 1);
    cyc(1, 0, 0);
    cyc(0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(1, 1, 0);
    cyc(0, 0, 0);
    // R8: second barrier during running drain
    for (int i = 0; i < 3; i++) cyc(1, 0, 0);
    cyc(0, 0, 1);
    cyc(0, 1, 0);
    cyc(1, 0, 1);
    for (int i = 0; i < 6; i++) cyc(0, 1, 0);
    // full with barrier and refused offer together
    for (int i = 0; i < 4; i++) cyc(1, 0, 0);
    cyc(1, 0, 1);
    for (int i = 0; i < 6; i++) cyc(0, 1, 0);
    // pseudo-random sweep over all input combinations
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] | lf[3], lf[1] & (lf[5] | lf[7]), lf[2] & lf[4] & lf[6]);
    end
    for (int i = 0; i < 8; i++) cyc(0, 1, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule